// File: doc/BRIEF.md
# Pattern Playback and Spy Capture Buffer

This block is a test memory placed on a trigger datapath, with two jobs. For playback, a host fills a pattern memory one word at a time through a command write port. A start command then sends the stored words to the downstream algorithm logic in place of live input. Playback runs either once or in a repeating loop. A programmable last-index register sets how many words make up the pattern.

For spy capture, the block records the sample stream passing through the datapath into a circular buffer. Once capture stops, the host reads the buffer back through a registered read port, and address 0 always returns the oldest stored sample. Capture does not begin when a command arrives. It begins on a shared spy strobe, which is driven by whichever board is configured as master. Every board samples that strobe, so all of them start recording on the same clock edge. In trigger-accept mode the buffer freezes on a level-1 accept and keeps the history that led up to it. In the other mode it freezes after one full pass of the buffer. A stop command ends playback and re-arms capture.

Top module: `pattern_spy_buf`

## Requirements
- R1: A word written with `ld_we` at `ld_addr` is stored, and playback later presents it at that pattern index.
- R2: After reset, and after loading, `pb_valid` stays 0 until a start command has been registered.
- R3: When `pb_start` is seen at a clock edge, `pb_valid` is 1 from that edge on and `pb_data` carries word 0, then words 1, 2, … on the following edges. `pb_data` is 0 whenever `pb_valid` is 0.
- R4: In single-shot mode (`pb_continuous`=0 at start), the word at the last index is held for one cycle. On the next edge `pb_valid` drops and the done flag rises.
- R5: In continuous mode, the word at the last index is followed by word 0, and this repeats. A `ctl_stop` seen at an edge clears `pb_valid` from that edge on.
- R6: `len_we` loads the last pattern index from `len_last`. After reset the last index is PAT_DEPTH-1.
- R7: With `spy_master`=1, `spy_go` seen at an edge drives `spy_sync_out` high for the following cycle. With `spy_master`=0, `spy_sync_out` stays 0.
- R8: An armed buffer records nothing and never freezes until `spy_sync_in` is 1. The sample present on the strobe edge is the first sample recorded.
- R9: With `spy_l1_mode`=0, the buffer freezes on the edge that records its SPY_DEPTH-th sample. Read address a then returns the a-th recorded sample.
- R10: With `spy_l1_mode`=1, recording wraps until an edge with `l1_accept`=1. That sample is recorded last and the buffer freezes. Address SPY_DEPTH-1 returns that sample and address 0 returns the oldest stored one. If the buffer has not yet wrapped, address 0 returns the first sample.
- R11: While frozen, the strobe, `l1_accept` and new samples leave the buffer contents unchanged.
- R12: `ctl_stop` clears the frozen state, and the next strobe starts a new capture.
- R13: `rd_data` reflects the `rd_addr` presented at the previous clock edge.
- R14: `status` bit 0 = playback active, bit 1 = single-shot done, bit 2 = spy frozen. All three are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Pattern word write strobe |
| ld_addr | input | PAW | Pattern word index |
| ld_data | input | DATA_W | Pattern word value |
| len_we | input | 1 | Last-index register write strobe |
| len_last | input | PAW | New last pattern index |
| pb_start | input | 1 | Start-playback command |
| pb_continuous | input | 1 | Playback mode taken at start: 1 loops, 0 runs once |
| ctl_stop | input | 1 | Stops playback and re-arms capture |
| pb_data | output | DATA_W | Pattern word driven to the algorithm input |
| pb_valid | output | 1 | High while playback is active |
| spy_master | input | 1 | This board drives the shared strobe |
| spy_go | input | 1 | Command to issue the strobe (master only) |
| spy_sync_out | output | 1 | Strobe driven onto the shared line |
| spy_sync_in | input | 1 | Shared strobe as seen by every board |
| spy_sample | input | DATA_W | Datapath sample to be recorded |
| spy_l1_mode | input | 1 | 1: freeze on accept; 0: freeze after one full pass |
| l1_accept | input | 1 | Level-1 accept event |
| rd_addr | input | SAW | Capture read index, 0 = oldest |
| rd_data | output | DATA_W | Captured sample, one cycle after `rd_addr` |
| status | output | 3 | {frozen, done, active} |

## Verification
The hardest condition to reach from the ports is a freeze on an accept that lands exactly where the circular buffer has wrapped. Only there does the oldest-first remapping of read addresses come into play. The bench feeds the buffer a counter that rises by one per cycle and loops the strobe output back onto the strobe input. From that it knows which sample value was present on the strobe edge. It lets the ring overrun before raising the accept and then checks both ends of the readout. Two further cases round this out: a short capture frozen before the buffer wraps, and strobes and accepts applied after the freeze.

// File: rtl/pspy_pkg.sv
package pspy_pkg;
    typedef enum logic [1:0] {
        SPY_ARMED  = 2'd0,
        SPY_RUN    = 2'd1,
        SPY_FROZEN = 2'd2
    } spy_state_e;

    localparam int ST_ACTIVE = 0;
    localparam int ST_DONE   = 1;
    localparam int ST_FROZEN = 2;
    localparam int ST_W      = 3;
endpackage

// File: rtl/pspy_pattern_mem.sv
module pspy_pattern_mem #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/pspy_playback.sv
module pspy_playback #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          len_we,
    input  logic [AW-1:0] len_last,
    input  logic          start,
    input  logic          cont_in,
    input  logic          stop,
    output logic          active,
    output logic          done,
    output logic [AW-1:0] idx
);
    typedef struct packed {
        logic          active;
        logic          cont;
        logic          done;
        logic [AW-1:0] idx;
        logic [AW-1:0] last;
    } pb_t;

    pb_t q, d;

    always_comb begin
        d = q;
        if (len_we) begin
            d.last = len_last;
        end
        if (stop) begin
            d.active = 1'b0;
        end else if (start) begin
            d.active = 1'b1;
            d.cont   = cont_in;
            d.done   = 1'b0;
            d.idx    = '0;
        end else if (q.active) begin
            if (q.idx >= q.last) begin
                if (q.cont) begin
                    d.idx = '0;
                end else begin
                    d.active = 1'b0;
                    d.done   = 1'b1;
                end
            end else begin
                d.idx = q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.active <= 1'b0;
            q.cont   <= 1'b0;
            q.done   <= 1'b0;
            q.idx    <= '0;
            q.last   <= '1;
        end else begin
            q <= d;
        end
    end

    assign active = q.active;
    assign done   = q.done;
    assign idx    = q.idx;

    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop) |=> (q.active && q.idx == '0 && !q.done));

    assert_single_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && !q.cont && q.idx >= q.last && !start && !stop)
        |=> (!q.active && q.done));

    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && q.cont && q.idx >= q.last && !start && !stop)
        |=> (q.active && q.idx == '0));

    assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !q.active);
endmodule

// File: rtl/pspy_capture.sv
module pspy_capture
    import pspy_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop,
    input  logic              sync_in,
    input  logic              l1_mode,
    input  logic              l1_accept,
    input  logic [DATA_W-1:0] sample,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              frozen
);
    typedef struct packed {
        spy_state_e        st;
        logic [AW-1:0]     wptr;
        logic              wrapped;
        logic [DATA_W-1:0] rdat;
    } cap_t;

    cap_t q, d;
    logic              wr_en;
    logic [AW-1:0]     rd_phys;
    logic              freeze_now;
    logic [DATA_W-1:0] ring_q [DEPTH];

    always_comb begin
        d          = q;
        wr_en      = 1'b0;
        freeze_now = 1'b0;
        rd_phys    = q.wrapped ? (q.wptr + rd_addr) : rd_addr;
        d.rdat     = ring_q[rd_phys];
        if (stop) begin
            d.st      = SPY_ARMED;
            d.wptr    = '0;
            d.wrapped = 1'b0;
        end else if ((q.st == SPY_RUN) || (q.st == SPY_ARMED && sync_in)) begin
            wr_en  = 1'b1;
            d.wptr = q.wptr + 1'b1;
            if (q.wptr == LAST) begin
                d.wrapped = 1'b1;
            end
            freeze_now = l1_mode ? l1_accept : (q.wptr == LAST);
            d.st       = freeze_now ? SPY_FROZEN : SPY_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st      <= SPY_ARMED;
            q.wptr    <= '0;
            q.wrapped <= 1'b0;
            q.rdat    <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ring_q[q.wptr] <= sample;
        end
    end

    assign rd_data = q.rdat;
    assign frozen  = (q.st == SPY_FROZEN);

    assert_armed_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SPY_ARMED && !sync_in && !stop) |=> (q.st == SPY_ARMED && $stable(q.wptr)));

    assert_frozen_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SPY_FROZEN && !stop) |=> (q.st == SPY_FROZEN && $stable(q.wptr) && $stable(q.wrapped)));

    assert_stop_rearm_R12: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (q.st == SPY_ARMED && q.wptr == '0 && !q.wrapped));
endmodule

// File: rtl/pattern_spy_buf.sv
module pattern_spy_buf
    import pspy_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int PAT_DEPTH = 16,
    parameter int SPY_DEPTH = 16,
    localparam int PAW      = $clog2(PAT_DEPTH),
    localparam int SAW      = $clog2(SPY_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic [PAW-1:0]    ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              len_we,
    input  logic [PAW-1:0]    len_last,
    input  logic              pb_start,
    input  logic              pb_continuous,
    input  logic              ctl_stop,
    output logic [DATA_W-1:0] pb_data,
    output logic              pb_valid,
    input  logic              spy_master,
    input  logic              spy_go,
    output logic              spy_sync_out,
    input  logic              spy_sync_in,
    input  logic [DATA_W-1:0] spy_sample,
    input  logic              spy_l1_mode,
    input  logic              l1_accept,
    input  logic [SAW-1:0]    rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [ST_W-1:0]   status
);
    logic              pb_active;
    logic              pb_done;
    logic [PAW-1:0]    pb_idx;
    logic [DATA_W-1:0] pat_word;
    logic              spy_frozen;
    logic              strobe_d, strobe_q;

    pspy_pattern_mem #(.DATA_W(DATA_W), .DEPTH(PAT_DEPTH)) u_pat (
        .clk   (clk),
        .we    (ld_we),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (pb_idx),
        .rdata (pat_word)
    );

    pspy_playback #(.DEPTH(PAT_DEPTH)) u_pb (
        .clk      (clk),
        .rst_n    (rst_n),
        .len_we   (len_we),
        .len_last (len_last),
        .start    (pb_start),
        .cont_in  (pb_continuous),
        .stop     (ctl_stop),
        .active   (pb_active),
        .done     (pb_done),
        .idx      (pb_idx)
    );

    pspy_capture #(.DATA_W(DATA_W), .DEPTH(SPY_DEPTH)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop      (ctl_stop),
        .sync_in   (spy_sync_in),
        .l1_mode   (spy_l1_mode),
        .l1_accept (l1_accept),
        .sample    (spy_sample),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .frozen    (spy_frozen)
    );

    always_comb begin
        strobe_d = spy_go & spy_master;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= strobe_d;
        end
    end

    assign spy_sync_out       = strobe_q;
    assign pb_valid           = pb_active;
    assign pb_data            = pb_active ? pat_word : '0;
    assign status[ST_ACTIVE]  = pb_active;
    assign status[ST_DONE]    = pb_done;
    assign status[ST_FROZEN]  = spy_frozen;

    assert_slave_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !spy_master |=> !spy_sync_out);

    assert_idle_output_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pb_start && !pb_valid) |=> (pb_data == '0 || pb_valid));
endmodule

// File: tb/pattern_spy_buf_test.sv
`timescale 1ns/1ps
module pattern_spy_buf_test;
    localparam int DW  = 16;
    localparam int PD  = 16;
    localparam int SD  = 16;
    localparam int PAW = 4;
    localparam int SAW = 4;

    typedef struct packed {
        logic       cont;
        logic [3:0] last;
        logic [7:0] seed;
    } pb_vec_t;

    localparam pb_vec_t VECS [6] = '{
        '{1'b0, 4'd15, 8'h10},
        '{1'b0, 4'd0,  8'h20},
        '{1'b1, 4'd3,  8'h30},
        '{1'b1, 4'd0,  8'h40},
        '{1'b0, 4'd6,  8'h55},
        '{1'b1, 4'd15, 8'h07}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           rst_n;
    logic           ld_we;
    logic [PAW-1:0] ld_addr;
    logic [DW-1:0]  ld_data;
    logic           len_we;
    logic [PAW-1:0] len_last;
    logic           pb_start, pb_continuous, ctl_stop;
    logic [DW-1:0]  pb_data;
    logic           pb_valid;
    logic           spy_master, spy_go, spy_sync_out, spy_sync_in;
    logic [DW-1:0]  spy_sample;
    logic           spy_l1_mode, l1_accept;
    logic [SAW-1:0] rd_addr;
    logic [DW-1:0]  rd_data;
    logic [2:0]     status;

    assign spy_sync_in = spy_sync_out;

    pattern_spy_buf #(.DATA_W(DW), .PAT_DEPTH(PD), .SPY_DEPTH(SD)) uut (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .len_we(len_we), .len_last(len_last), .pb_start(pb_start),
        .pb_continuous(pb_continuous), .ctl_stop(ctl_stop), .pb_data(pb_data),
        .pb_valid(pb_valid), .spy_master(spy_master), .spy_go(spy_go),
        .spy_sync_out(spy_sync_out), .spy_sync_in(spy_sync_in), .spy_sample(spy_sample),
        .spy_l1_mode(spy_l1_mode), .l1_accept(l1_accept), .rd_addr(rd_addr),
        .rd_data(rd_data), .status(status)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        spy_sample = spy_sample + 1'b1;
    endtask

    function automatic logic [DW-1:0] pat(input logic [7:0] seed, input int i);
        return {seed, 8'(i * 7)};
    endfunction

    task automatic load_all(input logic [7:0] seed);
        for (int i = 0; i < PD; i++) begin
            ld_we = 1'b1; ld_addr = PAW'(i); ld_data = pat(seed, i);
            step();
        end
        ld_we = 1'b0;
    endtask

    task automatic run_pb(input logic cont, input logic [3:0] last, input logic [7:0] seed,
                          input bit write_len);
        int obs;
        int len;
        load_all(seed);
        if (write_len) begin
            len_we = 1'b1; len_last = last;
            step();
            len_we = 1'b0;
        end
        chk("R2 idle before start", pb_valid, 0);
        len = int'(last) + 1;
        obs = cont ? 2 * len + 2 : len + 3;
        pb_continuous = cont; pb_start = 1'b1;
        step();
        pb_start = 1'b0;
        for (int k = 0; k < obs; k++) begin
            if (cont || k < len) begin
                chk("R3 R5 valid", pb_valid, 1);
                chk("R1 R3 R5 word", pb_data, pat(seed, k % len));
                chk("R14 active bit", status[0], 1);
            end else begin
                chk("R4 valid drop", pb_valid, 0);
                chk("R3 zero when idle", pb_data, 0);
                chk("R4 R14 done bit", status[1], 1);
            end
            step();
        end
        if (cont) begin
            ctl_stop = 1'b1;
            step();
            ctl_stop = 1'b0;
            chk("R5 stop clears valid", pb_valid, 0);
            chk("R5 no done after stop", status[1], 0);
        end
    endtask

    task automatic read_spy(input int a, output logic [DW-1:0] v);
        rd_addr = SAW'(a);
        step();
        v = rd_data;
    endtask

    task automatic go_pulse();
        spy_go = 1'b1;
        step();
        spy_go = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] v, w, r;
        rst_n = 1'b0; ld_we = 0; ld_addr = 0; ld_data = 0; len_we = 0; len_last = 0;
        pb_start = 0; pb_continuous = 0; ctl_stop = 0; spy_master = 0; spy_go = 0;
        spy_sample = 0; spy_l1_mode = 0; l1_accept = 0; rd_addr = 0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R2 valid after reset", pb_valid, 0);
        chk("R14 status after reset", status, 0);
        chk("R7 strobe after reset", spy_sync_out, 0);

        // R6: default last index covers the whole pattern memory
        run_pb(1'b0, 4'd15, 8'h99, 1'b0);

        foreach (VECS[n]) begin
            run_pb(VECS[n].cont, VECS[n].last, VECS[n].seed, 1'b1);
        end

        // R7 R8: slave board neither drives the strobe nor captures
        ctl_stop = 1'b1; step(); ctl_stop = 1'b0;
        spy_master = 1'b0; spy_l1_mode = 1'b0;
        spy_go = 1'b1; step();
        chk("R7 slave strobe", spy_sync_out, 0);
        spy_go = 1'b0;
        repeat (20) step();
        chk("R8 armed no freeze", status[2], 0);

        // R9: single pass capture from a master strobe
        spy_master = 1'b1;
        go_pulse();
        chk("R7 master strobe high", spy_sync_out, 1);
        v = spy_sample;
        repeat (15) step();
        chk("R7 strobe one cycle", spy_sync_out, 0);
        chk("R9 not frozen before full", status[2], 0);
        step();
        chk("R9 frozen when full", status[2], 1);
        read_spy(0, r);  chk("R8 R9 first sample", r, v);
        read_spy(7, r);  chk("R9 R13 mid sample", r, v + 16'd7);
        read_spy(15, r); chk("R9 last sample", r, v + 16'd15);

        // R11: frozen buffer ignores strobe, accept and new samples
        go_pulse();
        l1_accept = 1'b1; step(); l1_accept = 1'b0;
        repeat (4) step();
        read_spy(0, r);  chk("R11 frozen addr0", r, v);
        read_spy(15, r); chk("R11 frozen addr15", r, v + 16'd15);
        chk("R11 still frozen", status[2], 1);

        // R12 R10: re-arm and freeze on accept after wrap
        ctl_stop = 1'b1; step(); ctl_stop = 1'b0;
        chk("R12 frozen cleared", status[2], 0);
        spy_l1_mode = 1'b1;
        go_pulse();
        v = spy_sample;
        repeat (19) step();
        chk("R10 running before accept", status[2], 0);
        w = spy_sample;
        l1_accept = 1'b1; step(); l1_accept = 1'b0;
        chk("R10 frozen on accept", status[2], 1);
        read_spy(15, r); chk("R10 accept sample last", r, w);
        read_spy(0, r);  chk("R10 oldest after wrap", r, w - 16'd15);
        read_spy(9, r);  chk("R10 middle after wrap", r, w - 16'd6);

        // R10: accept before the buffer wraps
        ctl_stop = 1'b1; step(); ctl_stop = 1'b0;
        go_pulse();
        v = spy_sample;
        step(); step();
        l1_accept = 1'b1; step(); l1_accept = 1'b0;
        chk("R10 short frozen", status[2], 1);
        read_spy(0, r); chk("R10 short oldest", r, v);
        read_spy(2, r); chk("R10 short accept sample", r, v + 16'd2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule